// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes each instruction in one clock cycle. It runs a small fixed-format subset: unsigned register add and subtract, OR with a zero-extended immediate, word load, word store, branch on equal and an absolute jump. It holds the program counter, a 32 x 32-bit register file, an ALU, an immediate extender, the operand and write-back multiplexers and a main decoder that drives every control point. Each cycle the current instruction is decoded and its operands are read. The result settles before the next clock edge, and on that edge the PC, the register file and the data memory all update together.

The instruction store is a read-only array that the parameter `IMEM_INIT` sets when the core is instantiated. The data store is a word array inside the core with a combinational read and a write on the clock edge. The only outputs are for observation. They show the current PC and the register write, if any, that the current instruction commits at the coming edge.

Top module: `scp_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, and reset takes effect without waiting for a clock edge. After release, the first instruction is fetched from byte address 0.
- R2: Opcode 0x00 (bits 31:26) with funct 0x21 (bits 5:0) writes rs + rt to rd, and funct 0x23 writes rs - rt to rd, both modulo 2^32. rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R3: Opcode 0x0D writes rs OR the zero-extended imm16 (bits 15:0) to rt.
- R4: Opcode 0x23 writes to rt the data word at byte address rs + sign-extended imm16. The word index is taken from the address bits above bit 1.
- R5: Opcode 0x2B writes rt into the data word at rs + sign-extended imm16 on the clock edge. It performs no register write.
- R6: Opcode 0x04 sets the next PC to PC+4 + sign-extended imm16 x 4 when rs equals rt, and to PC+4 otherwise.
- R7: Register 0 always reads as zero. A write aimed at it is dropped and never appears on `wr_en_o`.
- R8: Any other opcode, and opcode 0x00 with any other funct, writes neither a register nor memory, and the PC advances by 4.
- R9: Opcode 0x02 sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R10: `wr_en_o`, `wr_addr_o` and `wr_data_o` show, during the cycle of the instruction, the register write that instruction commits at the next edge. `pc_o` shows the address of the instruction that is executing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every storage element updates on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wr_en_o | output | 1 | A register write commits at the coming edge |
| wr_addr_o | output | 5 | Destination register of that write |
| wr_data_o | output | 32 | Value being written |

## Verification
Every result of this core belongs to the same cycle as its instruction. The write-back outputs are valid while the instruction is current, and the effect of a branch or jump is first visible as the `pc_o` of the following cycle. The bench queues one expected item per executed instruction, made up of the PC and the write event. The monitor pops one item at each falling clock edge, half a cycle after the rising edge that moved the PC. As a result, a wrong branch target or a wrong write shows up at the exact instruction. A store is proven only indirectly, by a later load of the same word one edge after the store commits.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    use_imm;
    logic    imm_signed;
    logic    mem_we;
    logic    wb_from_mem;
    logic    reg_we;
    alu_op_e alu_op;
    logic    is_branch;
    logic    is_jump;
  } ctrl_t;
endpackage

// File: rtl/scp_decoder.sv
module scp_decoder
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADDU || funct == FN_SUBU) begin
          ctrl.dst_is_rd = 1'b1;
          ctrl.reg_we    = 1'b1;
          ctrl.alu_op    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.use_imm     = 1'b1;
        ctrl.imm_signed  = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm    = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.mem_we     = 1'b1;
      end
      OP_BEQ: begin
        ctrl.imm_signed = 1'b1;
        ctrl.alu_op     = ALU_SUB;
        ctrl.is_branch  = 1'b1;
      end
      OP_J: begin
        ctrl.is_jump = 1'b1;
      end
      default: ctrl = ctrl;
    endcase
  end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic [AW-1:0]    ra_idx,
  input  logic [AW-1:0]    rb_idx,
  output logic [WIDTH-1:0] ra_data,
  output logic [WIDTH-1:0] rb_data,
  input  logic             w_en,
  input  logic [AW-1:0]    w_idx,
  input  logic [WIDTH-1:0] w_data
);
  logic [WIDTH-1:0] regs [NREGS];
  logic             w_commit;

  assign w_commit = w_en && (w_idx != '0);

  always_ff @(posedge clk) begin
    if (w_commit) begin
      regs[w_idx] <= w_data;
    end
  end

  assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y,
  output logic             zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter logic [IMEM_WORDS-1:0][XLEN-1:0] IMEM_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] pc_o,
  output logic            wr_en_o,
  output logic [4:0]      wr_addr_o,
  output logic [XLEN-1:0] wr_data_o
);
  localparam int IIDX_W = $clog2(IMEM_WORDS);
  localparam int DIDX_W = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, pc_d, pc_seq, pc_br, pc_jmp;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;
  logic [4:0]      f_rs, f_rt, f_rd, dest;
  logic [15:0]     f_imm;
  logic [XLEN-1:0] imm_sx, imm_ext;
  logic [XLEN-1:0] bus_a, bus_b, alu_b, alu_y, mem_q, wb_val;
  logic            alu_zero;
  logic [DIDX_W-1:0] d_idx;
  logic            unused_bits;

  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // fetch
  assign instr = IMEM_INIT[pc_q[IIDX_W+1:2]];

  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  scp_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign dest = ctrl.dst_is_rd ? f_rd : f_rt;

  scp_regfile #(.NREGS(32), .WIDTH(XLEN)) u_rf (
    .clk     (clk),
    .ra_idx  (f_rs),
    .rb_idx  (f_rt),
    .ra_data (bus_a),
    .rb_data (bus_b),
    .w_en    (ctrl.reg_we),
    .w_idx   (dest),
    .w_data  (wb_val)
  );

  // immediate extension
  assign imm_sx  = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign imm_ext = ctrl.imm_signed ? imm_sx : {{(XLEN-16){1'b0}}, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : bus_b;

  scp_alu #(.WIDTH(XLEN)) u_alu (
    .op   (ctrl.alu_op),
    .a    (bus_a),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: combinational read, edge write
  assign d_idx = alu_y[DIDX_W+1:2];
  assign mem_q = dmem[d_idx];

  always_ff @(posedge clk) begin
    if (ctrl.mem_we) begin
      dmem[d_idx] <= bus_b;
    end
  end

  assign wb_val = ctrl.wb_from_mem ? mem_q : alu_y;

  // next PC
  assign pc_seq = pc_q + 32'd4;
  assign pc_br  = pc_seq + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_jmp = {pc_seq[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)                    pc_d = pc_jmp;
    else if (ctrl.is_branch && alu_zero) pc_d = pc_br;
    else                                 pc_d = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IIDX_W+2], alu_y[1:0],
                         alu_y[XLEN-1:DIDX_W+2], instr[10:6]};

  assign pc_o      = pc_q;
  assign wr_en_o   = ctrl.reg_we && (dest != 5'd0);
  assign wr_addr_o = dest;
  assign wr_data_o = wb_val;
endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk
  import scp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_o,
  input logic        wr_en_o,
  input logic [4:0]  wr_addr_o,
  input logic [31:0] instr
);
  logic [5:0] op;
  logic       known;

  assign op    = instr[31:26];
  assign known = (op == OP_RTYPE && (instr[5:0] == FN_ADDU || instr[5:0] == FN_SUBU)) ||
                 op == OP_ORI || op == OP_LW || op == OP_SW || op == OP_BEQ || op == OP_J;

  assert_pc_reset_R1: assert property (@(negedge clk) !rst_n |-> pc_o == 32'd0);

  assert_r0_never_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_addr_o != 5'd0);

  assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SW) |-> !wr_en_o);

  assert_unknown_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> !wr_en_o);

  assert_unknown_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !known |=> pc_o == $past(pc_o) + 32'd4);

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_J) |=> pc_o[27:0] == {$past(instr[25:0]), 2'b00});
endmodule

bind scp_core scp_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc_o      (pc_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .instr     (instr)
);

// File: tb/tb_scp_core.sv
`timescale 1ns/1ps
module tb_scp_core;
  typedef logic [63:0][31:0] prog_t;

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    string       req;
  } exp_t;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic prog_t build_prog();
    prog_t p;
    p = '0;
    p[0]  = enc_i(6'h0D, 5'd0, 5'd1, 16'h1234);   // ori r1
    p[1]  = enc_i(6'h0D, 5'd0, 5'd2, 16'hFFF0);   // ori r2, zero-extended
    p[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h21);       // addu r3
    p[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h23);       // subu r4 (wraps)
    p[4]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0008);   // sw r3 -> 8
    p[5]  = enc_i(6'h0D, 5'd0, 5'd5, 16'h0010);   // ori r5 = 16
    p[6]  = enc_i(6'h23, 5'd5, 5'd6, 16'hFFF8);   // lw r6, -8(r5)
    p[7]  = enc_i(6'h0D, 5'd1, 5'd0, 16'h0055);   // ori into r0
    p[8]  = enc_r(5'd0, 5'd1, 5'd7, 6'h21);       // addu r7 = r0 + r1
    p[9]  = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);   // beq not taken
    p[10] = enc_i(6'h04, 5'd3, 5'd6, 16'h0002);   // beq taken -> 0x34
    p[11] = enc_i(6'h0D, 5'd0, 5'd8, 16'h0001);   // skipped
    p[12] = enc_i(6'h0D, 5'd0, 5'd8, 16'h0002);   // skipped
    p[13] = enc_r(5'd1, 5'd2, 5'd9, 6'h00);       // unknown funct
    p[14] = enc_i(6'h3F, 5'd1, 5'd10, 16'h1111);  // unknown opcode
    p[15] = {6'h02, 26'h0000011};                 // j -> 0x44
    p[16] = enc_i(6'h0D, 5'd0, 5'd8, 16'h0003);   // skipped
    p[17] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);   // branch to self
    return p;
  endfunction

  localparam prog_t PROG = build_prog();

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_o;
  logic        wr_en_o;
  logic [4:0]  wr_addr_o;
  logic [31:0] wr_data_o;

  int n_checks = 0;
  int n_fails  = 0;
  exp_t q[$];

  scp_core #(.IMEM_WORDS(64), .DMEM_WORDS(64), .IMEM_INIT(PROG)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_o      (pc_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] pc, input logic we, input logic [4:0] wa,
                      input logic [31:0] wd, input string req);
    exp_t e;
    e.pc = pc; e.we = we; e.wa = wa; e.wd = wd; e.req = req;
    q.push_back(e);
  endtask

  // monitor: one executed instruction per cycle, sampled after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "pc", pc_o, e.pc);
        check(e.req, "write enable (R10)", {31'd0, wr_en_o}, {31'd0, e.we});
        if (e.we) begin
          check(e.req, "write addr (R10)", {27'd0, wr_addr_o}, {27'd0, e.wa});
          check(e.req, "write data", wr_data_o, e.wd);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int guard;
    push(32'h00, 1'b1, 5'd1, 32'h0000_1234, "R3");
    push(32'h04, 1'b1, 5'd2, 32'h0000_FFF0, "R3");
    push(32'h08, 1'b1, 5'd3, 32'h0001_1224, "R2");
    push(32'h0C, 1'b1, 5'd4, 32'hFFFF_1244, "R2");
    push(32'h10, 1'b0, 5'd0, 32'h0,         "R5");
    push(32'h14, 1'b1, 5'd5, 32'h0000_0010, "R3");
    push(32'h18, 1'b1, 5'd6, 32'h0001_1224, "R4");
    push(32'h1C, 1'b0, 5'd0, 32'h0,         "R7");
    push(32'h20, 1'b1, 5'd7, 32'h0000_1234, "R7");
    push(32'h24, 1'b0, 5'd0, 32'h0,         "R6");
    push(32'h28, 1'b0, 5'd0, 32'h0,         "R6");
    push(32'h34, 1'b0, 5'd0, 32'h0,         "R8");
    push(32'h38, 1'b0, 5'd0, 32'h0,         "R8");
    push(32'h3C, 1'b0, 5'd0, 32'h0,         "R9");
    push(32'h44, 1'b0, 5'd0, 32'h0,         "R6");
    push(32'h44, 1'b0, 5'd0, 32'h0,         "R6");
    push(32'h44, 1'b0, 5'd0, 32'h0,         "R6");

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "pc in reset", pc_o, 32'h0);

    @(posedge clk);
    #1;
    rst_n = 1'b1;

    guard = 0;
    while (q.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    #3;
    check("R1", "queue drained", q.size(), 0);

    // asynchronous reset mid-cycle
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R1", "pc after async reset", pc_o, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule